// File: doc/BRIEF.md
# Neighbour-Shared Lookup RAM Arbiter

A lookup RAM that belongs to one core in a ring of cores. It has two ports. Port A is reserved for the owning core, which can read and write through it. Port B has two users. The first is the local streamer, which only reads entries in order to drive DAC or pin outputs. The second is the adjacent core one step down the ring, which can read and write. Each core reaches the RAM of the core one step up through that core's port B. As a result, every core can exchange data with both of its ring neighbours.

The neighbour and the streamer can both request port B in the same cycle. When they do, the neighbour is served and the streamer is held off. The streamer keeps its request and address asserted until its grant comes back. For each port, read data arrives one clock after the request is accepted, together with a valid strobe.

Every neighbour access sets a sticky flag: one flag for writes and a separate flag for reads. The owning core can poll these flags, wait on them, or route them to an interrupt. It clears both flags with a single strobe.

Top module: `lut_nbr_ram`

## Requirements
- R1: The RAM stores DEPTH words of DW bits (512 x 32 by default). A word written through port A is returned by a later port-A read of the same address.
- R2: A read on any port that is accepted at a clock edge drives that port's valid output high during the next cycle, with the data beside it. The data is the word as it stood before any write accepted at that same edge.
- R3: The neighbour is always granted port B when it requests (`nb_gnt_o` equals `nb_req_i`). If the neighbour and the streamer request in the same cycle, the neighbour wins.
- R4: A denied streamer request has `st_gnt_o` low and produces no `st_rvalid_o` in the next cycle. When the held request is later granted, it returns the correct word.
- R5: A word written by the neighbour through port B is returned by a later port-A read of that address.
- R6: If port A and the neighbour write the same address in the same cycle, the stored value is the port-A data.
- R7: `evt_wr_o` rises in the cycle after a neighbour write. It stays high until it is cleared.
- R8: `evt_rd_o` rises in the cycle after a neighbour read, independently of `evt_wr_o`. It stays high until it is cleared.
- R9: `evt_clr_i` clears both flags at the next edge. If a neighbour access arrives in the same cycle as the clear, the matching flag is set and the other flag is cleared.
- R10: While reset is held and directly after it, and with no requests present, all grants, valid outputs and event flags are low.
- R11: Streamer traffic never changes the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Port A access request |
| a_we_i | input | 1 | Port A write enable (1 = write, 0 = read) |
| a_addr_i | input | AW | Port A word address |
| a_wdata_i | input | DW | Port A write data |
| a_rvalid_o | output | 1 | Port A read data valid |
| a_rdata_o | output | DW | Port A read data |
| st_req_i | input | 1 | Streamer read request, held until granted |
| st_addr_i | input | AW | Streamer word address |
| st_gnt_o | output | 1 | Streamer access accepted this cycle |
| st_rvalid_o | output | 1 | Streamer read data valid |
| st_rdata_o | output | DW | Streamer read data |
| nb_req_i | input | 1 | Neighbour access request |
| nb_we_i | input | 1 | Neighbour write enable (1 = write, 0 = read) |
| nb_addr_i | input | AW | Neighbour word address |
| nb_wdata_i | input | DW | Neighbour write data |
| nb_gnt_o | output | 1 | Neighbour access accepted this cycle |
| nb_rvalid_o | output | 1 | Neighbour read data valid |
| nb_rdata_o | output | DW | Neighbour read data |
| evt_clr_i | input | 1 | Strobe that clears both event flags |
| evt_wr_o | output | 1 | Sticky flag: the neighbour has written |
| evt_rd_o | output | 1 | Sticky flag: the neighbour has read |

## Verification
The bench builds the block with DEPTH=32 and DW=16. With only 32 addresses, random traffic on both ports often lands on the same word. That produces same-cycle write collisions and read-while-write cases in large numbers. It also lets every word be preloaded in a few cycles so the reference array starts fully known. Because the streamer holds its request while the neighbour requests on about half the cycles, denial followed by retry happens often. Clears frequently coincide with neighbour accesses, which exercises the set-over-clear rule.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_NBR  = 2'd1,
    B_STR  = 2'd2
  } b_owner_e;

  localparam int unsigned EVT_N  = 2;
  localparam int unsigned EVT_WR = 0;
  localparam int unsigned EVT_RD = 1;
endpackage

// File: rtl/lut_dp_mem.sv
module lut_dp_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic          a_rvalid_o,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] a_rdata_q, b_rdata_q;
  logic          a_rvalid_q;

  // port A write placed last so it wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (b_en_i && b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_en_i && a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    if (a_en_i && !a_we_i) a_rdata_q <= mem_q[a_addr_i];
    if (b_en_i && !b_we_i) b_rdata_q <= mem_q[b_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) a_rvalid_q <= 1'b0;
    else         a_rvalid_q <= a_en_i && !a_we_i;
  end

  assign a_rvalid_o = a_rvalid_q;
  assign a_rdata_o  = a_rdata_q;
  assign b_rdata_o  = b_rdata_q;
endmodule

// File: rtl/lut_portb_arb.sv
module lut_portb_arb
  import lut_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_req_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic          nb_req_i,
  input  logic          nb_we_i,
  input  logic [AW-1:0] nb_addr_i,
  input  logic [DW-1:0] nb_wdata_i,
  output logic          st_gnt_o,
  output logic          nb_gnt_o,
  output logic          b_en_o,
  output logic          b_we_o,
  output logic [AW-1:0] b_addr_o,
  output logic [DW-1:0] b_wdata_o,
  output logic          st_rvalid_o,
  output logic          nb_rvalid_o
);
  b_owner_e owner, rd_owner_q;

  // fixed priority: neighbour first
  always_comb begin
    if (nb_req_i)      owner = B_NBR;
    else if (st_req_i) owner = B_STR;
    else               owner = B_IDLE;
  end

  always_comb begin
    b_en_o    = 1'b0;
    b_we_o    = 1'b0;
    b_addr_o  = '0;
    b_wdata_o = '0;
    unique case (owner)
      B_NBR: begin
        b_en_o    = 1'b1;
        b_we_o    = nb_we_i;
        b_addr_o  = nb_addr_i;
        b_wdata_o = nb_wdata_i;
      end
      B_STR: begin
        b_en_o   = 1'b1;
        b_addr_o = st_addr_i;
      end
      default: ;
    endcase
  end

  assign nb_gnt_o = (owner == B_NBR);
  assign st_gnt_o = (owner == B_STR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rd_owner_q <= B_IDLE;
    else if (owner == B_NBR && nb_we_i) rd_owner_q <= B_IDLE;
    else                               rd_owner_q <= owner;
  end

  assign nb_rvalid_o = (rd_owner_q == B_NBR);
  assign st_rvalid_o = (rd_owner_q == B_STR);
endmodule

// File: rtl/lut_nbr_events.sv
module lut_nbr_events
  import lut_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nb_acc_i,
  input  logic             nb_we_i,
  input  logic             clr_i,
  output logic [EVT_N-1:0] evt_o
);
  logic [EVT_N-1:0] set;

  assign set[EVT_WR] = nb_acc_i && nb_we_i;
  assign set[EVT_RD] = nb_acc_i && !nb_we_i;

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    logic flag_q;
    // a new access beats a concurrent clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (set[i]) flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
    assign evt_o[i] = flag_q;
  end
endmodule

// File: rtl/lut_nbr_ram.sv
module lut_nbr_ram
  import lut_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_req_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic          a_rvalid_o,
  output logic [DW-1:0] a_rdata_o,
  input  logic          st_req_i,
  input  logic [AW-1:0] st_addr_i,
  output logic          st_gnt_o,
  output logic          st_rvalid_o,
  output logic [DW-1:0] st_rdata_o,
  input  logic          nb_req_i,
  input  logic          nb_we_i,
  input  logic [AW-1:0] nb_addr_i,
  input  logic [DW-1:0] nb_wdata_i,
  output logic          nb_gnt_o,
  output logic          nb_rvalid_o,
  output logic [DW-1:0] nb_rdata_o,
  input  logic          evt_clr_i,
  output logic          evt_wr_o,
  output logic          evt_rd_o
);
  logic          b_en, b_we;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic [EVT_N-1:0] evt;

  lut_portb_arb #(.DEPTH(DEPTH), .DW(DW)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_req_i   (st_req_i),
    .st_addr_i  (st_addr_i),
    .nb_req_i   (nb_req_i),
    .nb_we_i    (nb_we_i),
    .nb_addr_i  (nb_addr_i),
    .nb_wdata_i (nb_wdata_i),
    .st_gnt_o   (st_gnt_o),
    .nb_gnt_o   (nb_gnt_o),
    .b_en_o     (b_en),
    .b_we_o     (b_we),
    .b_addr_o   (b_addr),
    .b_wdata_o  (b_wdata),
    .st_rvalid_o(st_rvalid_o),
    .nb_rvalid_o(nb_rvalid_o)
  );

  lut_dp_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (a_req_i),
    .a_we_i    (a_we_i),
    .a_addr_i  (a_addr_i),
    .a_wdata_i (a_wdata_i),
    .a_rvalid_o(a_rvalid_o),
    .a_rdata_o (a_rdata_o),
    .b_en_i    (b_en),
    .b_we_i    (b_we),
    .b_addr_i  (b_addr),
    .b_wdata_i (b_wdata),
    .b_rdata_o (b_rdata)
  );

  lut_nbr_events u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nb_acc_i(nb_gnt_o),
    .nb_we_i (nb_we_i),
    .clr_i   (evt_clr_i),
    .evt_o   (evt)
  );

  // shared port-B read bus; the valid strobes say whose it is
  assign st_rdata_o = b_rdata;
  assign nb_rdata_o = b_rdata;
  assign evt_wr_o   = evt[EVT_WR];
  assign evt_rd_o   = evt[EVT_RD];
endmodule

// File: rtl/lut_nbr_ram_chk.sv
module lut_nbr_ram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic a_req_i,
  input logic a_we_i,
  input logic a_rvalid_o,
  input logic st_req_i,
  input logic st_gnt_o,
  input logic st_rvalid_o,
  input logic nb_req_i,
  input logic nb_we_i,
  input logic nb_gnt_o,
  input logic nb_rvalid_o,
  input logic evt_clr_i,
  input logic evt_wr_o,
  input logic evt_rd_o
);
  p_nbr_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_req_i && st_req_i) |-> (nb_gnt_o && !st_gnt_o));
  p_nbr_always_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nb_req_i |-> nb_gnt_o);
  p_one_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nb_gnt_o, st_gnt_o}));
  p_st_gnt_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_gnt_o |-> st_req_i);
  p_st_denied_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_gnt_o |=> !st_rvalid_o);
  p_st_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_gnt_o |=> st_rvalid_o);
  p_nb_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_req_i && !nb_we_i) |=> nb_rvalid_o);
  p_a_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_req_i && !a_we_i) |=> a_rvalid_o);
  p_evt_wr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_req_i && nb_we_i) |=> evt_wr_o);
  p_evt_wr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_wr_o && !evt_clr_i) |=> evt_wr_o);
  p_evt_rd_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_req_i && !nb_we_i) |=> evt_rd_o);
  p_evt_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd_o && !evt_clr_i) |=> evt_rd_o);
  p_evt_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_clr_i && !nb_req_i) |=> (!evt_wr_o && !evt_rd_o));
endmodule

bind lut_nbr_ram lut_nbr_ram_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_req_i    (a_req_i),
  .a_we_i     (a_we_i),
  .a_rvalid_o (a_rvalid_o),
  .st_req_i   (st_req_i),
  .st_gnt_o   (st_gnt_o),
  .st_rvalid_o(st_rvalid_o),
  .nb_req_i   (nb_req_i),
  .nb_we_i    (nb_we_i),
  .nb_gnt_o   (nb_gnt_o),
  .nb_rvalid_o(nb_rvalid_o),
  .evt_clr_i  (evt_clr_i),
  .evt_wr_o   (evt_wr_o),
  .evt_rd_o   (evt_rd_o)
);

// File: tb/sim_lut_nbr_ram.sv
module sim_lut_nbr_ram;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          a_req = 0, a_we = 0, st_req = 0, nb_req = 0, nb_we = 0, evt_clr = 0;
  logic [AW-1:0] a_addr = '0, st_addr = '0, nb_addr = '0;
  logic [DW-1:0] a_wdata = '0, nb_wdata = '0;
  logic          a_rvalid, st_gnt, st_rvalid, nb_gnt, nb_rvalid, evt_wr, evt_rd;
  logic [DW-1:0] a_rdata, st_rdata, nb_rdata;

  lut_nbr_ram #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(a_req), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata),
    .a_rvalid_o(a_rvalid), .a_rdata_o(a_rdata),
    .st_req_i(st_req), .st_addr_i(st_addr), .st_gnt_o(st_gnt),
    .st_rvalid_o(st_rvalid), .st_rdata_o(st_rdata),
    .nb_req_i(nb_req), .nb_we_i(nb_we), .nb_addr_i(nb_addr), .nb_wdata_i(nb_wdata),
    .nb_gnt_o(nb_gnt), .nb_rvalid_o(nb_rvalid), .nb_rdata_o(nb_rdata),
    .evt_clr_i(evt_clr), .evt_wr_o(evt_wr), .evt_rd_o(evt_rd)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] model [DEPTH];
  logic          m_evt_wr = 0, m_evt_rd = 0;

  // scoreboard queues: expected valid, expected data, requirement tag
  logic          qa_v[$], qs_v[$], qn_v[$];
  logic [DW-1:0] qa_d[$], qs_d[$], qn_d[$];
  string         qa_t[$], qs_t[$], qn_t[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(
    input logic ar, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
    input logic sr, input logic [AW-1:0] sa,
    input logic nr, input logic nw, input logic [AW-1:0] na, input logic [DW-1:0] nd,
    input logic clr, input string tag, output logic sg);
    @(negedge clk);
    chk("R7 evt_wr", {31'd0, evt_wr}, {31'd0, m_evt_wr});
    chk("R8 evt_rd", {31'd0, evt_rd}, {31'd0, m_evt_rd});
    a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad;
    st_req = sr; st_addr = sa;
    nb_req = nr; nb_we = nw; nb_addr = na; nb_wdata = nd;
    evt_clr = clr;
    #1;
    sg = sr && !nr;
    chk("R3 nb_gnt", {31'd0, nb_gnt}, {31'd0, nr});
    chk("R4 st_gnt", {31'd0, st_gnt}, {31'd0, sg});
    qa_v.push_back(ar && !aw); qa_d.push_back(model[aa]); qa_t.push_back(tag);
    qs_v.push_back(sg);        qs_d.push_back(model[sa]); qs_t.push_back(tag);
    qn_v.push_back(nr && !nw); qn_d.push_back(model[na]); qn_t.push_back(tag);
    if (nr && nw) model[na] = nd;
    if (ar && aw) model[aa] = ad;
    m_evt_wr = (nr && nw)  || (m_evt_wr && !clr);
    m_evt_rd = (nr && !nw) || (m_evt_rd && !clr);
  endtask

  task automatic idle(input int n);
    logic g;
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, '0, 0, 0, '0, '0, 0, "R2 idle", g);
  endtask

  // monitor: one expected item per port per stepped cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qa_v.size() > 0) begin
        logic v; logic [DW-1:0] d; string t;
        v = qa_v.pop_front(); d = qa_d.pop_front(); t = qa_t.pop_front();
        chk({t, " a_rvalid"}, {31'd0, a_rvalid}, {31'd0, v});
        if (v) chk({t, " a_rdata"}, {16'd0, a_rdata}, {16'd0, d});
      end
      if (qs_v.size() > 0) begin
        logic v; logic [DW-1:0] d; string t;
        v = qs_v.pop_front(); d = qs_d.pop_front(); t = qs_t.pop_front();
        chk({t, " st_rvalid"}, {31'd0, st_rvalid}, {31'd0, v});
        if (v) chk({t, " st_rdata"}, {16'd0, st_rdata}, {16'd0, d});
      end
      if (qn_v.size() > 0) begin
        logic v; logic [DW-1:0] d; string t;
        v = qn_v.pop_front(); d = qn_d.pop_front(); t = qn_t.pop_front();
        chk({t, " nb_rvalid"}, {31'd0, nb_rvalid}, {31'd0, v});
        if (v) chk({t, " nb_rdata"}, {16'd0, nb_rdata}, {16'd0, d});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic g;
    logic          sp;
    logic [AW-1:0] sa;
    // R10: state held in and just out of reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 in-reset evt", {30'd0, evt_wr, evt_rd}, 32'd0);
    chk("R10 in-reset rvalid", {29'd0, a_rvalid, st_rvalid, nb_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 post-reset gnt", {30'd0, st_gnt, nb_gnt}, 32'd0);
    chk("R10 post-reset rvalid", {29'd0, a_rvalid, st_rvalid, nb_rvalid}, 32'd0);
    chk("R10 post-reset evt", {30'd0, evt_wr, evt_rd}, 32'd0);

    // R1: fill every word through port A, then read some back
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, AW'(i), DW'(16'h1000 + i * 7), 0, '0, 0, 0, '0, '0, 0, "R1", g);
    for (int i = 0; i < DEPTH; i += 5)
      step(1, 0, AW'(i), '0, 0, '0, 0, 0, '0, '0, 0, "R1", g);

    // R2: read-before-write at the same edge, across ports
    step(1, 1, AW'(3), 16'hBEEF, 1, AW'(3), 0, 0, '0, '0, 0, "R2", g);
    step(1, 0, AW'(3), '0, 0, '0, 0, 0, '0, '0, 0, "R2", g);

    // R4: streamer denied by neighbour, held, then granted
    step(0, 0, '0, '0, 1, AW'(9), 1, 0, AW'(4), '0, 0, "R4", g);
    chk("R4 denied grant flag", {31'd0, g}, 32'd0);
    step(0, 0, '0, '0, 1, AW'(9), 0, 0, '0, '0, 0, "R4", g);
    chk("R4 retry granted", {31'd0, g}, 32'd1);

    // R5: neighbour write seen by port A
    step(0, 0, '0, '0, 0, '0, 1, 1, AW'(12), 16'h5A5A, 0, "R5", g);
    step(1, 0, AW'(12), '0, 0, '0, 0, 0, '0, '0, 0, "R5", g);

    // R6: same-address write collision, port A wins
    step(1, 1, AW'(20), 16'hAAAA, 0, '0, 1, 1, AW'(20), 16'h5555, 0, "R6", g);
    step(1, 0, AW'(20), '0, 0, '0, 1, 0, AW'(20), '0, 0, "R6", g);

    // R9: clear alone, then clear together with a neighbour write
    step(0, 0, '0, '0, 0, '0, 0, 0, '0, '0, 1, "R9", g);
    step(0, 0, '0, '0, 0, '0, 1, 0, AW'(1), '0, 0, "R9", g);
    step(0, 0, '0, '0, 0, '0, 1, 1, AW'(2), 16'h0F0F, 1, "R9", g);
    step(0, 0, '0, '0, 0, '0, 0, 0, '0, '0, 0, "R9", g);
    idle(2);

    // R11: streamer reads only; contents unchanged afterwards
    for (int i = 0; i < 6; i++)
      step(0, 0, '0, '0, 1, AW'(i), 0, 0, '0, '0, 0, "R11", g);
    for (int i = 0; i < 6; i++)
      step(1, 0, AW'(i), '0, 0, '0, 0, 0, '0, '0, 0, "R11", g);

    // random concurrent traffic; streamer holds until granted
    sp = 0; sa = '0;
    for (int i = 0; i < 600; i++) begin
      if (!sp) begin
        sp = 1'($urandom % 2);
        sa = AW'($urandom % DEPTH);
      end
      step(1'($urandom % 2), 1'($urandom % 2), AW'($urandom % DEPTH), DW'($urandom),
           sp, sa,
           1'($urandom % 2), 1'($urandom % 2), AW'($urandom % DEPTH), DW'($urandom),
           ($urandom % 8) == 0, "R11 R6 R4 random", g);
      if (g) sp = 0;
    end
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule